// File: doc/BRIEF.md
# Serial Extrinsic Node Unit

This block is one node of a message-passing decoder, built in compact serial form. A node of degree d receives its d incoming edge messages over one input port, one per cycle. It then returns d outgoing messages over one output port, one per cycle. Each outgoing message is extrinsic: it combines every incoming message of the node except the one that arrived on the same edge. Signed magnitudes combine by addition and saturate to the 8-bit range. The separate sign bits combine by exclusive-OR.

Each edge is written into a small per-node store while a running total and a running sign parity are built. After the edge flagged as last, the unit reads the stored edges back in arrival order. For each one it removes that edge's own contribution from the total and the parity. An optional intrinsic term, sampled together with the first edge of a node, is folded into the total and parity. This term lets the same unit act as a variable node (with the channel value) or as a check node (with the term disabled).

Two node stores alternate. A new node can therefore fill while the previous one drains. `in_ready` drops only when both stores hold nodes that have not finished draining.

Top module: `sxnu_top`

## Requirements
- R1: During and directly after reset, `out_valid` and `out_last` are 0 and `in_ready` is 1.
- R2: For a node whose edges carry signed magnitudes e_1..e_d, output n carries the sum of all e_m with m different from n, plus the intrinsic magnitude when enabled, saturated to [-128, 127].
- R3: Output n's sign is the XOR of every other edge's sign bit of the node, further XORed with the intrinsic sign when the intrinsic term is enabled.
- R4: `intr_en`, `intr_mag` and `intr_sgn` are sampled only on the accepted first edge of a node. With `intr_en` = 0 the intrinsic term adds 0 and leaves the sign parity unchanged.
- R5: An extrinsic sum above 127 is output as 127, and one below -128 is output as -128.
- R6: Outputs leave in the same edge order as the inputs were accepted. When no earlier node is draining, the first output is valid in the cycle after the edge with `in_last` is accepted.
- R7: `out_last` is 1 on the final output of each node and 0 on every other output.
- R8: A node ends at the accepted edge with `in_last` = 1 and has a degree between 1 and 8. A node of degree 1 outputs the intrinsic term alone, or 0 with sign 0 when the intrinsic term is disabled.
- R9: `in_ready` is 0 exactly when two completed nodes have not yet finished draining. An input presented while `in_ready` is 0 is not taken and changes no output.
- R10: Once a node starts draining, `out_valid` stays 1 on every cycle up to and including that node's final output, with one output per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| intr_en | input | 1 | Include the intrinsic term in this node |
| intr_mag | input | 8 | Intrinsic signed magnitude |
| intr_sgn | input | 1 | Intrinsic sign bit |
| in_valid | input | 1 | Edge message present |
| in_mag | input | 8 | Edge signed magnitude |
| in_sgn | input | 1 | Edge sign bit |
| in_last | input | 1 | This edge is the last of its node |
| in_ready | output | 1 | Unit can take an edge this cycle |
| out_valid | output | 1 | Extrinsic output present |
| out_mag | output | 8 | Extrinsic saturated signed magnitude |
| out_sgn | output | 1 | Extrinsic sign bit |
| out_last | output | 1 | Final output of the node |

## Verification
The assertions take for granted that no node carries more than eight edges before its `in_last`; a counter in the checker flags any violation of this. They also assume the output side never stalls, since the unit has no output back-pressure. The stimulus keeps node degrees between 1 and 8 and holds each edge steady until `in_ready` has been high for a cycle. Bursts of short nodes behind long ones push the unit into the both-stores-busy condition, while the port-level model predicts every accepted edge and every output.

// File: rtl/sxnu_pkg.sv
package sxnu_pkg;

    // Life cycle of one node store
    typedef enum logic [1:0] {
        BK_EMPTY = 2'd0,   // holds no node, next write starts a node
        BK_FILL  = 2'd1,   // collecting edges of a node
        BK_DRAIN = 2'd2    // node complete, extrinsic outputs streaming
    } bank_st_e;

endpackage

// File: rtl/sxnu_bank.sv
module sxnu_bank
    import sxnu_pkg::*;
#(
    parameter int MAX_DEG = 8,
    parameter int MAG_W   = 8,
    parameter int ACC_W   = 13
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic signed [MAG_W-1:0] wr_mag,
    input  logic                    wr_sgn,
    input  logic                    wr_last,
    input  logic                    intr_en,
    input  logic signed [MAG_W-1:0] intr_mag,
    input  logic                    intr_sgn,
    input  logic                    rd_en,
    output bank_st_e                st,
    output logic signed [MAG_W-1:0] rd_mag,
    output logic                    rd_sgn,
    output logic                    rd_last,
    output logic signed [ACC_W-1:0] tot,
    output logic                    par
);
    localparam int IDX_W = (MAX_DEG > 1) ? $clog2(MAX_DEG) : 1;
    localparam int CNT_W = $clog2(MAX_DEG + 1);

    bank_st_e                st_q, st_d;
    logic [CNT_W-1:0]        cnt_q, rd_idx_q, cnt_eff;
    logic signed [ACC_W-1:0] tot_q, base_tot, wr_ext, intr_ext;
    logic                    par_q, base_par;
    logic signed [MAG_W-1:0] mag_mem [MAX_DEG];
    logic                    sgn_mem [MAX_DEG];
    logic [IDX_W-1:0]        wr_ptr, rd_ptr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= BK_EMPTY;
        else        st_q <= st_d;
    end

    // Transitions: START (empty->fill), CLOSE (fill->drain),
    // SINGLE (empty->drain for degree one), RELEASE (drain->empty)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_EMPTY: if (wr_en) st_d = wr_last ? BK_DRAIN : BK_FILL;
            BK_FILL:  if (wr_en && wr_last) st_d = BK_DRAIN;
            BK_DRAIN: if (rd_en && rd_last) st_d = BK_EMPTY;
            default:  st_d = BK_EMPTY;
        endcase
    end

    assign wr_ext   = {{(ACC_W-MAG_W){wr_mag[MAG_W-1]}}, wr_mag};
    assign intr_ext = intr_en ? {{(ACC_W-MAG_W){intr_mag[MAG_W-1]}}, intr_mag} : '0;
    assign cnt_eff  = (st_q == BK_EMPTY) ? '0 : cnt_q;
    assign base_tot = (st_q == BK_EMPTY) ? intr_ext : tot_q;
    assign base_par = (st_q == BK_EMPTY) ? (intr_en & intr_sgn) : par_q;
    assign wr_ptr   = cnt_eff[IDX_W-1:0];
    assign rd_ptr   = rd_idx_q[IDX_W-1:0];

    // Running total, parity and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tot_q    <= '0;
            par_q    <= 1'b0;
            cnt_q    <= '0;
            rd_idx_q <= '0;
        end else begin
            if (wr_en) begin
                tot_q <= base_tot + wr_ext;
                par_q <= base_par ^ wr_sgn;
                cnt_q <= cnt_eff + CNT_W'(1);
            end
            if (wr_en && wr_last)  rd_idx_q <= '0;
            else if (rd_en)        rd_idx_q <= rd_idx_q + CNT_W'(1);
        end
    end

    // Edge store, written in arrival order
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mag_mem[wr_ptr] <= wr_mag;
            sgn_mem[wr_ptr] <= wr_sgn;
        end
    end

    // Outputs of the store
    always_comb begin
        st      = st_q;
        tot     = tot_q;
        par     = par_q;
        rd_mag  = mag_mem[rd_ptr];
        rd_sgn  = sgn_mem[rd_ptr];
        rd_last = (rd_idx_q + CNT_W'(1)) == cnt_q;
    end

endmodule

// File: rtl/sxnu_extr.sv
module sxnu_extr #(
    parameter int MAG_W = 8,
    parameter int ACC_W = 13
) (
    input  logic signed [ACC_W-1:0] tot,
    input  logic                    par,
    input  logic signed [MAG_W-1:0] own_mag,
    input  logic                    own_sgn,
    output logic signed [MAG_W-1:0] ext_mag,
    output logic                    ext_sgn
);
    localparam int SAT_HI = 2 ** (MAG_W - 1) - 1;
    localparam int SAT_LO = -(2 ** (MAG_W - 1));

    logic signed [ACC_W-1:0] diff;

    always_comb begin
        diff    = tot - {{(ACC_W-MAG_W){own_mag[MAG_W-1]}}, own_mag};
        ext_sgn = par ^ own_sgn;
        if (int'(diff) > SAT_HI)
            ext_mag = {1'b0, {(MAG_W-1){1'b1}}};
        else if (int'(diff) < SAT_LO)
            ext_mag = {1'b1, {(MAG_W-1){1'b0}}};
        else
            ext_mag = diff[MAG_W-1:0];
    end

endmodule

// File: rtl/sxnu_top.sv
module sxnu_top
    import sxnu_pkg::*;
#(
    parameter int MAX_DEG = 8,
    parameter int MAG_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    intr_en,
    input  logic signed [MAG_W-1:0] intr_mag,
    input  logic                    intr_sgn,
    input  logic                    in_valid,
    input  logic signed [MAG_W-1:0] in_mag,
    input  logic                    in_sgn,
    input  logic                    in_last,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic signed [MAG_W-1:0] out_mag,
    output logic                    out_sgn,
    output logic                    out_last
);
    localparam int ACC_W   = MAG_W + $clog2(MAX_DEG + 1) + 1;
    localparam int N_BANKS = 2;

    logic                    wr_sel, rd_sel, accept;
    bank_st_e                bk_st   [N_BANKS];
    logic signed [MAG_W-1:0] bk_mag  [N_BANKS];
    logic                    bk_sgn  [N_BANKS];
    logic                    bk_last [N_BANKS];
    logic signed [ACC_W-1:0] bk_tot  [N_BANKS];
    logic                    bk_par  [N_BANKS];

    assign in_ready  = bk_st[wr_sel] != BK_DRAIN;
    assign accept    = in_valid && in_ready;
    assign out_valid = bk_st[rd_sel] == BK_DRAIN;
    assign out_last  = out_valid && bk_last[rd_sel];

    for (genvar g = 0; g < N_BANKS; g++) begin : g_bank
        sxnu_bank #(
            .MAX_DEG (MAX_DEG),
            .MAG_W   (MAG_W),
            .ACC_W   (ACC_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (accept && (wr_sel == 1'(g))),
            .wr_mag   (in_mag),
            .wr_sgn   (in_sgn),
            .wr_last  (in_last),
            .intr_en  (intr_en),
            .intr_mag (intr_mag),
            .intr_sgn (intr_sgn),
            .rd_en    (out_valid && (rd_sel == 1'(g))),
            .st       (bk_st[g]),
            .rd_mag   (bk_mag[g]),
            .rd_sgn   (bk_sgn[g]),
            .rd_last  (bk_last[g]),
            .tot      (bk_tot[g]),
            .par      (bk_par[g])
        );
    end

    // Store selection: write side flips on a closed node, read side on a drained one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_sel <= 1'b0;
            rd_sel <= 1'b0;
        end else begin
            if (accept && in_last)    wr_sel <= ~wr_sel;
            if (out_valid && out_last) rd_sel <= ~rd_sel;
        end
    end

    sxnu_extr #(
        .MAG_W (MAG_W),
        .ACC_W (ACC_W)
    ) u_extr (
        .tot     (bk_tot[rd_sel]),
        .par     (bk_par[rd_sel]),
        .own_mag (bk_mag[rd_sel]),
        .own_sgn (bk_sgn[rd_sel]),
        .ext_mag (out_mag),
        .ext_sgn (out_sgn)
    );

endmodule

// File: rtl/sxnu_chk.sv
module sxnu_chk #(
    parameter int MAX_DEG = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_last,
    input logic in_ready,
    input logic out_valid,
    input logic out_last
);
    localparam int CNT_W = $clog2(MAX_DEG + 1) + 1;

    logic [CNT_W-1:0] edge_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             edge_cnt <= '0;
        else if (in_valid && in_ready && in_last) edge_cnt <= '0;
        else if (in_valid && in_ready)            edge_cnt <= edge_cnt + CNT_W'(1);
    end

    AST_NODE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (edge_cnt < CNT_W'(MAX_DEG))); // R8

    AST_FIRST_OUT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last && !out_valid) |=> out_valid); // R6

    AST_STREAM_CONT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |=> out_valid); // R10

    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |-> out_valid); // R9

    AST_READY_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $past(out_valid && out_last)); // R9

    AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid); // R7

endmodule

bind sxnu_top sxnu_chk #(.MAX_DEG(MAX_DEG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last)
);

// File: tb/tb_sxnu_top.sv
module tb_sxnu_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic intr_en = 1'b0, intr_sgn = 1'b0;
    logic signed [7:0] intr_mag = '0;
    logic in_valid = 1'b0, in_sgn = 1'b0, in_last = 1'b0;
    logic signed [7:0] in_mag = '0;
    logic in_ready, out_valid, out_sgn, out_last;
    logic signed [7:0] out_mag;

    always #4 clk = ~clk;

    sxnu_top dut (
        .clk(clk), .rst_n(rst_n),
        .intr_en(intr_en), .intr_mag(intr_mag), .intr_sgn(intr_sgn),
        .in_valid(in_valid), .in_mag(in_mag), .in_sgn(in_sgn), .in_last(in_last),
        .in_ready(in_ready), .out_valid(out_valid), .out_mag(out_mag),
        .out_sgn(out_sgn), .out_last(out_last)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    bit running = 0;

    // Behavioural reference model
    int q_mag[$];
    bit q_sgn[$];
    bit q_last[$];
    int pending = 0;
    int cur_mag[$];
    bit cur_sgn[$];
    int cur_intr = 0;
    bit cur_isgn = 0;

    function automatic int sat8(int v);
        if (v > 127)  return 127;
        if (v < -128) return -128;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            q_mag.delete(); q_sgn.delete(); q_last.delete();
            cur_mag.delete(); cur_sgn.delete(); pending = 0;
        end else begin
            bit acc;
            acc = in_valid && (pending < 2);
            if (q_mag.size() > 0) begin
                if (q_last[0]) pending--;
                void'(q_mag.pop_front()); void'(q_sgn.pop_front()); void'(q_last.pop_front());
            end
            if (acc) begin
                if (cur_mag.size() == 0) begin
                    cur_intr = intr_en ? int'(intr_mag) : 0;
                    cur_isgn = intr_en & intr_sgn;
                end
                cur_mag.push_back(int'(in_mag));
                cur_sgn.push_back(in_sgn);
                if (in_last) begin
                    int tot;
                    bit par;
                    tot = cur_intr; par = cur_isgn;
                    foreach (cur_mag[i]) begin tot += cur_mag[i]; par ^= cur_sgn[i]; end
                    foreach (cur_mag[i]) begin
                        q_mag.push_back(sat8(tot - cur_mag[i]));
                        q_sgn.push_back(par ^ cur_sgn[i]);
                        q_last.push_back(i == cur_mag.size() - 1);
                    end
                    pending++;
                    cur_mag.delete(); cur_sgn.delete();
                end
            end
        end
    end

    task automatic fail(string req, string what, int act, int exp);
        n_bad++;
        $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    endtask

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            bit ev;
            ev = q_mag.size() > 0;
            n_cmp++;
            if (in_ready !== (pending < 2)) fail("R9", "in_ready", int'(in_ready), int'(pending < 2));
            if (out_valid !== ev) fail("R6 R10", "out_valid", int'(out_valid), int'(ev));
            else if (ev) begin
                if (out_mag !== 8'(q_mag[0])) fail("R2 R4 R5 R8", "out_mag", int'(out_mag), q_mag[0]);
                if (out_sgn !== q_sgn[0]) fail("R3", "out_sgn", int'(out_sgn), int'(q_sgn[0]));
                if (out_last !== q_last[0]) fail("R7", "out_last", int'(out_last), int'(q_last[0]));
            end else if (out_last !== 1'b0) fail("R7", "out_last idle", int'(out_last), 0);
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
            summary();
        end
    end

    int nm[8];
    bit ns[8];

    task automatic send_node(int deg, bit ie, int im, bit is, int gap);
        for (int k = 0; k < deg; k++) begin
            bit rdy;
            intr_en = ie; intr_mag = 8'(im); intr_sgn = is;
            in_valid = 1'b1; in_mag = 8'(nm[k]); in_sgn = ns[k]; in_last = (k == deg - 1);
            do begin
                rdy = in_ready;
                @(negedge clk);
            end while (!rdy);
            in_valid = 1'b0;
            // junk values on idle cycles must not be taken
            in_mag = 8'($urandom_range(255)); in_last = 1'($urandom_range(1));
            intr_en = 1'($urandom_range(1)); intr_mag = 8'($urandom_range(255));
            for (int w = 0; w < gap; w++) @(negedge clk);
        end
    endtask

    task automatic fill_const(int deg, int m, bit s);
        for (int k = 0; k < deg; k++) begin nm[k] = m; ns[k] = s; end
    endtask

    task automatic fill_rand(int deg);
        for (int k = 0; k < deg; k++) begin
            nm[k] = int'($urandom_range(255)) - 128;
            ns[k] = 1'($urandom_range(1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || out_last !== 1'b0 || in_ready !== 1'b1)
            fail("R1", "reset outputs valid/last/ready", {out_valid, out_last, in_ready}, 3'b001);
        rst_n = 1'b1;
        running = 1;
        @(negedge clk);
        n_cmp++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1)
            fail("R1", "after reset valid/ready", {out_valid, in_ready}, 2'b01);

        // R8: degree one, with and without intrinsic
        fill_const(1, 55, 1);        send_node(1, 0, 0, 0, 3);
        fill_const(1, -20, 0);       send_node(1, 1, -90, 1, 3);
        // R2 R3: check-node style, degree 6
        nm = '{3, -7, 12, 40, -1, 9, 0, 0}; ns = '{1, 0, 1, 1, 0, 0, 0, 0};
        send_node(6, 0, 0, 0, 4);
        // R4: variable-node style with intrinsic, degree 3
        nm = '{10, -30, 5, 0, 0, 0, 0, 0}; ns = '{0, 1, 1, 0, 0, 0, 0, 0};
        send_node(3, 1, 17, 1, 4);
        // R5: positive and negative saturation at full degree
        fill_const(8, 127, 0);       send_node(8, 1, 127, 0, 2);
        fill_const(8, -128, 1);      send_node(8, 1, -128, 1, 2);
        // R9: long node then short nodes back to back, exercising in_ready low
        fill_rand(8);                send_node(8, 1, 33, 0, 0);
        fill_rand(2);                send_node(2, 0, 0, 0, 0);
        fill_rand(1);                send_node(1, 1, -5, 1, 0);
        fill_rand(3);                send_node(3, 0, 0, 0, 0);
        repeat (12) @(negedge clk);
        // Random mix of degrees, gaps and intrinsic use
        for (int n = 0; n < 300; n++) begin
            int d;
            d = 1 + $urandom_range(7);
            fill_rand(d);
            send_node(d, 1'($urandom_range(1)), int'($urandom_range(255)) - 128,
                      1'($urandom_range(1)), (n % 4 == 0) ? 0 : int'($urandom_range(2)));
        end
        while (q_mag.size() > 0 || pending != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        summary();
    end
endmodule